// File: doc/BRIEF.md
# Page-Offset-Indexed Cache with Physical Tag Check

This block is a direct-mapped data cache whose line index is taken only from the page-offset part of an address. Because those bits are the same before and after translation, the line arrays can be read while a separate translation unit is still producing the physical frame number. In the following cycle, the tag stored in the line is compared with that frame number. The cache therefore has physical tags but does not wait for translation before it starts its array read.

The requester presents the 12 offset bits of a virtual address together with a lookup strobe. In the same cycle, the translation unit supplies the physical frame number and a flag that marks the translation as usable. One cycle later the block reports hit or miss, the 32-bit line word, and the two byte-displacement bits. The word is not shifted, so the requester aligns it. A refill port writes one line: its word, its physical frame tag and its valid bit. At the default size there are 1024 lines of 4 bytes, 4 KB in total, which is exactly one page.

Top module: `ovl_pt_cache`

## Requirements
- R1: After reset every line is invalid, so a lookup misses even when translation is usable, and rsp_valid is low until the first lookup.
- R2: A lookup strobed in cycle N gives rsp_valid high in cycle N+1 and in no other cycle; while rsp_valid is high exactly one of rsp_hit and rsp_miss is high.
- R3: The line index is lk_ofs[11:2]; the displacement bits lk_ofs[1:0] never change which line is read.
- R4: A hit requires the selected line to be valid and its stored 20-bit tag to equal xl_pfn sampled with the lookup; a tag mismatch gives a miss.
- R5: When xl_ok is low with the lookup, the response is a miss whatever the line holds.
- R6: A refill with fill_en high writes fill_data, tag fill_pfn and a set valid bit into line fill_idx; a later lookup of that index with the same frame number hits and returns fill_data.
- R7: A refill to a line that is already occupied replaces it, so the old frame number then misses at that index.
- R8: rsp_disp equals lk_ofs[1:0] of the lookup being answered, and rsp_data is the whole line word, not shifted.
- R9: On a miss rsp_data is zero.
- R10: When a lookup and a refill to the same index fall in the same cycle, the lookup sees the line contents from before the refill.
- R11: With rsp_valid low, rsp_hit, rsp_miss and rsp_data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_req | input | 1 | Lookup strobe |
| lk_ofs | input | 12 | Page-offset bits of the virtual address |
| xl_pfn | input | 20 | Translated physical frame number, same cycle as lk_req |
| xl_ok | input | 1 | Translation is usable (low on translation miss or fault) |
| fill_en | input | 1 | Refill write strobe |
| fill_idx | input | 10 | Line index written by the refill |
| fill_pfn | input | 20 | Physical frame tag written by the refill |
| fill_data | input | 32 | Line word written by the refill |
| rsp_valid | output | 1 | A lookup response is present |
| rsp_hit | output | 1 | Response is a hit |
| rsp_miss | output | 1 | Response is a miss |
| rsp_data | output | 32 | Line word on a hit, zero otherwise |
| rsp_disp | output | 2 | Byte displacement of the answered lookup |

## Verification
A wrong valid bit or a wrong stored tag appears as a wrong hit or miss on the first lookup of that index after the damage. The bench keeps its own copy of every line and compares each response one cycle after the strobe. A wrong index split or a wrong refill address leaves the expected line untouched or changes a different line, and that shows as wrong data or a wrong hit on the next lookup of either index. The random phase uses only a few indices and frame numbers, so most lookups land on lines that have been written before. A timing slip between the registered array read and the registered frame number makes the compare use operands from different cycles, and the next response then disagrees with the model.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
    parameter int ADDR_W     = 32;
    parameter int PAGE_OFS_W = 12;
    parameter int BYTE_W     = 2;
    parameter int DATA_W     = 32;
    localparam int IDX_W     = PAGE_OFS_W - BYTE_W;
    localparam int TAG_W     = ADDR_W - PAGE_OFS_W;
    localparam int LINES     = 1 << IDX_W;
endpackage

// File: rtl/ovl_addr_split.sv
module ovl_addr_split #(
    parameter int PAGE_OFS_W = ovl_pkg::PAGE_OFS_W,
    parameter int BYTE_W     = ovl_pkg::BYTE_W,
    localparam int IDX_W     = PAGE_OFS_W - BYTE_W
) (
    input  logic [PAGE_OFS_W-1:0] ofs,
    output logic [IDX_W-1:0]      idx,
    output logic [BYTE_W-1:0]     disp
);
    // Only untranslated offset bits reach the index.
    always_comb begin
        idx  = ofs[PAGE_OFS_W-1:BYTE_W];
        disp = ofs[BYTE_W-1:0];
    end
endmodule

// File: rtl/ovl_line_store.sv
module ovl_line_store #(
    parameter int IDX_W  = ovl_pkg::IDX_W,
    parameter int TAG_W  = ovl_pkg::TAG_W,
    parameter int DATA_W = ovl_pkg::DATA_W,
    localparam int LINES = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rd_vld,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } rd_t;

    logic [LINES-1:0]  vld_d, vld_q;
    rd_t               rd_d, rd_q;
    logic [TAG_W-1:0]  tag_mem  [LINES];
    logic [DATA_W-1:0] data_mem [LINES];

    always_comb begin
        vld_d = vld_q;
        if (wr_en) begin
            vld_d[wr_idx] = 1'b1;
        end
        // Read takes the contents before any same-cycle write.
        rd_d.vld  = vld_q[rd_idx];
        rd_d.tag  = tag_mem[rd_idx];
        rd_d.data = data_mem[rd_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            rd_q  <= '0;
        end else begin
            vld_q <= vld_d;
            rd_q  <= rd_d;
        end
    end

    // Tag and data arrays carry no reset; the valid vector guards them.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            data_mem[wr_idx] <= wr_data;
        end
    end

    always_comb begin
        rd_vld  = rd_q.vld;
        rd_tag  = rd_q.tag;
        rd_data = rd_q.data;
    end
endmodule

// File: rtl/ovl_tag_match.sv
module ovl_tag_match #(
    parameter int TAG_W = ovl_pkg::TAG_W
) (
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] frame,
    input  logic             line_vld,
    input  logic             xlat_ok,
    output logic             match
);
    logic [TAG_W-1:0] bit_eq;

    for (genvar b = 0; b < TAG_W; b++) begin : g_bit
        assign bit_eq[b] = ~(line_tag[b] ^ frame[b]);
    end

    assign match = line_vld & xlat_ok & (&bit_eq);
endmodule

// File: rtl/ovl_pt_cache.sv
module ovl_pt_cache #(
    parameter int PAGE_OFS_W = ovl_pkg::PAGE_OFS_W,
    parameter int BYTE_W     = ovl_pkg::BYTE_W,
    parameter int TAG_W      = ovl_pkg::TAG_W,
    parameter int DATA_W     = ovl_pkg::DATA_W,
    localparam int IDX_W     = PAGE_OFS_W - BYTE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lk_req,
    input  logic [PAGE_OFS_W-1:0] lk_ofs,
    input  logic [TAG_W-1:0]      xl_pfn,
    input  logic                  xl_ok,
    input  logic                  fill_en,
    input  logic [IDX_W-1:0]      fill_idx,
    input  logic [TAG_W-1:0]      fill_pfn,
    input  logic [DATA_W-1:0]     fill_data,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic                  rsp_miss,
    output logic [DATA_W-1:0]     rsp_data,
    output logic [BYTE_W-1:0]     rsp_disp
);
    typedef struct packed {
        logic              req;
        logic              ok;
        logic [TAG_W-1:0]  pfn;
        logic [BYTE_W-1:0] disp;
    } stage_t;

    stage_t            st_d, st_q;
    logic [IDX_W-1:0]  lk_idx;
    logic [BYTE_W-1:0] lk_disp;
    logic              line_vld;
    logic [TAG_W-1:0]  line_tag;
    logic [DATA_W-1:0] line_data;
    logic              match;

    ovl_addr_split #(
        .PAGE_OFS_W (PAGE_OFS_W),
        .BYTE_W     (BYTE_W)
    ) split_i (
        .ofs  (lk_ofs),
        .idx  (lk_idx),
        .disp (lk_disp)
    );

    ovl_line_store #(
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (lk_idx),
        .wr_en   (fill_en),
        .wr_idx  (fill_idx),
        .wr_tag  (fill_pfn),
        .wr_data (fill_data),
        .rd_vld  (line_vld),
        .rd_tag  (line_tag),
        .rd_data (line_data)
    );

    // Translation result is registered alongside the array read.
    always_comb begin
        st_d.req  = lk_req;
        st_d.ok   = xl_ok;
        st_d.pfn  = xl_pfn;
        st_d.disp = lk_disp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    ovl_tag_match #(
        .TAG_W (TAG_W)
    ) match_i (
        .line_tag (line_tag),
        .frame    (st_q.pfn),
        .line_vld (line_vld),
        .xlat_ok  (st_q.ok),
        .match    (match)
    );

    always_comb begin
        rsp_valid = st_q.req;
        rsp_hit   = st_q.req & match;
        rsp_miss  = st_q.req & ~match;
        rsp_data  = rsp_hit ? line_data : '0;
        rsp_disp  = st_q.disp;
    end
endmodule

// File: rtl/ovl_pt_cache_chk.sv
module ovl_pt_cache_chk #(
    parameter int PAGE_OFS_W = 12,
    parameter int BYTE_W     = 2,
    parameter int DATA_W     = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  lk_req,
    input logic [PAGE_OFS_W-1:0] lk_ofs,
    input logic                  xl_ok,
    input logic                  rsp_valid,
    input logic                  rsp_hit,
    input logic                  rsp_miss,
    input logic [DATA_W-1:0]     rsp_data,
    input logic [BYTE_W-1:0]     rsp_disp
);
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid); // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid); // R2
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_hit, rsp_miss})); // R2
    AST_XLAT_BAD_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !xl_ok) |=> rsp_miss); // R5
    AST_DISP_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (rsp_disp == $past(lk_ofs[BYTE_W-1:0]))); // R8
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_data == '0)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_miss && rsp_data == '0)); // R11
endmodule

bind ovl_pt_cache ovl_pt_cache_chk #(
    .PAGE_OFS_W (PAGE_OFS_W),
    .BYTE_W     (BYTE_W),
    .DATA_W     (DATA_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_req    (lk_req),
    .lk_ofs    (lk_ofs),
    .xl_ok     (xl_ok),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_data  (rsp_data),
    .rsp_disp  (rsp_disp)
);

// File: tb/ovl_pt_cache_tb_top.sv
module ovl_pt_cache_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LINES      = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [11:0] lk_ofs = '0;
    logic [19:0] xl_pfn = '0;
    logic        xl_ok = 1'b0;
    logic        fill_en = 1'b0;
    logic [9:0]  fill_idx = '0;
    logic [19:0] fill_pfn = '0;
    logic [31:0] fill_data = '0;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [31:0] rsp_data;
    logic [1:0]  rsp_disp;

    int n_checks = 0;
    int n_fails  = 0;

    bit [LINES-1:0] m_vld;
    logic [19:0]    m_tag  [LINES];
    logic [31:0]    m_data [LINES];

    always #(CLK_PERIOD/2) clk = ~clk;

    ovl_pt_cache dut_i (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_ofs(lk_ofs),
        .xl_pfn(xl_pfn), .xl_ok(xl_ok), .fill_en(fill_en), .fill_idx(fill_idx),
        .fill_pfn(fill_pfn), .fill_data(fill_data), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_data(rsp_data), .rsp_disp(rsp_disp)
    );

    function automatic bit exp_hit(logic [11:0] ofs, logic [19:0] pfn, logic ok);
        return ok && m_vld[ofs[11:2]] && (m_tag[ofs[11:2]] == pfn);
    endfunction

    function automatic logic [31:0] exp_data(logic [11:0] ofs, logic [19:0] pfn, logic ok);
        return exp_hit(ofs, pfn, ok) ? m_data[ofs[11:2]] : 32'h0;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Lookup, optionally with a refill in the same cycle; response checked next cycle.
    task automatic access(string req, logic [11:0] ofs, logic [19:0] pfn, logic ok,
                          bit do_fill, logic [9:0] fi, logic [19:0] ft, logic [31:0] fd);
        bit          eh;
        logic [31:0] ed;
        eh = exp_hit(ofs, pfn, ok);
        ed = exp_data(ofs, pfn, ok);
        lk_req = 1'b1; lk_ofs = ofs; xl_pfn = pfn; xl_ok = ok;
        fill_en = do_fill; fill_idx = fi; fill_pfn = ft; fill_data = fd;
        @(posedge clk);
        @(negedge clk);
        lk_req = 1'b0; fill_en = 1'b0;
        if (do_fill) begin
            m_vld[fi] = 1'b1; m_tag[fi] = ft; m_data[fi] = fd;
        end
        check(req, {61'd0, rsp_valid, rsp_hit, rsp_miss}, {61'd0, 1'b1, eh, !eh});
        check(req, {30'd0, rsp_disp, rsp_data}, {30'd0, ofs[1:0], ed});
    endtask

    task automatic lookup(string req, logic [11:0] ofs, logic [19:0] pfn, logic ok);
        access(req, ofs, pfn, ok, 1'b0, 10'd0, 20'd0, 32'd0);
    endtask

    task automatic refill(logic [9:0] fi, logic [19:0] ft, logic [31:0] fd);
        fill_en = 1'b1; fill_idx = fi; fill_pfn = ft; fill_data = fd;
        @(posedge clk);
        @(negedge clk);
        fill_en = 1'b0;
        m_vld[fi] = 1'b1; m_tag[fi] = ft; m_data[fi] = fd;
        check("R11 idle", {61'd0, rsp_valid, rsp_hit, rsp_miss}, 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd7117;
        void'($urandom(seed));
        m_vld = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        lookup("R1 empty cache miss", 12'h0A4, 20'h00000, 1'b1);
        lookup("R1 empty cache miss", 12'hFFF, 20'hFFFFF, 1'b1);
        // R6: refill then hit
        refill(10'h029, 20'h12345, 32'hDEADBEEF);
        lookup("R6 hit after refill", 12'h0A4, 20'h12345, 1'b1);
        // R3/R8: other displacements read the same word unshifted
        lookup("R3 R8 disp 3 same line", 12'h0A7, 20'h12345, 1'b1);
        lookup("R3 R8 disp 1 same line", 12'h0A5, 20'h12345, 1'b1);
        // R4: tag mismatch
        lookup("R4 tag mismatch miss", 12'h0A4, 20'h12344, 1'b1);
        // R5 / R9: translation not usable
        lookup("R5 R9 xlat fault miss", 12'h0A4, 20'h12345, 1'b0);
        // R7: replacement
        refill(10'h029, 20'h0BEEF, 32'h01234567);
        lookup("R7 old tag misses", 12'h0A4, 20'h12345, 1'b1);
        lookup("R7 new tag hits", 12'h0A4, 20'h0BEEF, 1'b1);
        // R10: same-cycle fill and lookup, same index
        access("R10 lookup sees pre-fill", 12'h0A4, 20'h0BEEF, 1'b1,
               1'b1, 10'h029, 20'h55555, 32'hCAFEF00D);
        lookup("R10 fill visible later", 12'h0A4, 20'h55555, 1'b1);
        access("R10 empty line same cycle", 12'h3FC, 20'h00777, 1'b1,
               1'b1, 10'h0FF, 20'h00777, 32'h0BADCAFE);
        lookup("R10 new line later", 12'h3FE, 20'h00777, 1'b1);
        // Top and bottom lines
        refill(10'h3FF, 20'hFFFFF, 32'hA5A5A5A5);
        refill(10'h000, 20'h00001, 32'h5A5A5A5A);
        lookup("R6 top line", 12'hFFC, 20'hFFFFF, 1'b1);
        lookup("R6 bottom line", 12'h003, 20'h00001, 1'b1);
        // Idle gap
        @(negedge clk);
        check("R2 R11 no response without request", {63'd0, rsp_valid}, 64'd0);
        // Random phase over few indices and frames
        for (int i = 0; i < 600; i++) begin
            logic [9:0]  idx;
            logic [19:0] tg;
            int          op;
            idx = 10'h100 + 10'($urandom_range(0, 7));
            tg  = 20'hA0000 + 20'($urandom_range(0, 3));
            op  = $urandom_range(0, 9);
            if (op < 3) begin
                refill(idx, tg, $urandom());
            end else if (op == 3) begin
                access("R10 random fill+lookup", {idx, 2'($urandom_range(0, 3))}, tg, 1'b1,
                       1'b1, 10'h100 + 10'($urandom_range(0, 7)), tg, $urandom());
            end else begin
                lookup("R4 R5 R6 random lookup", {idx, 2'($urandom_range(0, 3))}, tg,
                       ($urandom_range(0, 7) != 0));
            end
        end
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule